// File: doc/BRIEF.md
# Radix-4 Booth Multiplier with Per-Operand Signedness

This block multiplies two 32-bit integers and returns the full 64-bit product in a single combinational pass. Each operand carries its own signedness flag. Both operands are first widened by one bit: the new top bit copies the old sign bit when the flag marks the operand signed, and is zero when it marks it unsigned. After that step a single signed multiply core handles all four flag combinations. Signed-by-signed, unsigned-by-unsigned and both mixed cases all come out of the same hardware.

The widened first operand is recoded into 17 radix-4 digits in the range -2 to +2. Each digit selects zero, the second operand, or twice the second operand, and inverts the selection when the digit is negative. This gives 17 sign-extended rows at even bit offsets. One extra row carries the +1 that completes each inversion into a two's-complement negation. A tree of 3:2 counters reduces all 18 rows to a sum and a carry vector, and one 64-bit adder produces the product. The block has no clock and no state. It is meant to sit inside a datapath stage whose own registers bound the timing path.

Top module: `booth_mul_top`

## Requirements
- R1: With both flags 0, the operands are unsigned and `product` equals op_a × op_b exactly.
- R2: With both flags 1, the operands are two's-complement and `product` equals their exact signed product as a 64-bit two's-complement value.
- R3: With op_a_signed = 1 and op_b_signed = 0, `product` equals (signed op_a) × (unsigned op_b) modulo 2^64.
- R4: With op_a_signed = 0 and op_b_signed = 1, `product` equals (unsigned op_a) × (signed op_b) modulo 2^64.
- R5: If either operand is zero, `product` is zero in every flag mode.
- R6: If op_a is 1, `product` equals op_b extended to 64 bits, by sign extension when op_b_signed = 1 and by zero extension when it is 0.
- R7: The flag of an operand whose bit 31 is 0 has no effect: toggling it leaves `product` unchanged.
- R8: With both flags 1 and both operands nonzero, bit 63 of `product` equals op_a[31] XOR op_b[31].
- R9: The block is purely combinational. `product` reflects the current inputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand; this one is Booth recoded |
| op_a_signed | input | 1 | 1: op_a is two's-complement, 0: op_a is unsigned |
| op_b | input | 32 | Second operand; the partial-product rows are formed from it |
| op_b_signed | input | 1 | 1: op_b is two's-complement, 0: op_b is unsigned |
| product | output | 64 | Full-width product |

## Verification
No register lies between the operand pins and `product`, so every result is due in the same clock period in which its operands are applied. The bench changes the operands and flags on the falling edge. It samples `product` 5 ns later, still before the next rising edge, so no check depends on process ordering at a clock edge. The reference value is computed in the bench from the flag-selected 64-bit extensions of both operands. Each check covers one operand set, and the set is held until it has been sampled.

// File: rtl/booth_mul_pkg.sv
// Package: booth_mul_pkg
// Shared types and elaboration-time helpers for the radix-4 Booth
// multiplier. Assumes nothing beyond constant-function evaluation.
package booth_mul_pkg;

    // Decoded control for one radix-4 digit: sign, x1 select, x2 select.
    typedef struct packed {
        logic neg;
        logic one;
        logic two;
    } booth_sel_t;

    // Rows left after one 3:2 counter level acting on n rows.
    function automatic int csa_next_rows(input int n);
        return 2 * (n / 3) + (n % 3);
    endfunction

    // Rows present at the input of tree level lvl, starting from n rows.
    function automatic int csa_rows_at(input int n, input int lvl);
        int r;
        r = n;
        for (int k = 0; k < lvl; k++) begin
            r = csa_next_rows(r);
        end
        return r;
    endfunction

    // Number of 3:2 levels needed to reach two rows from n rows.
    function automatic int csa_levels(input int n);
        int r;
        int cnt;
        r   = n;
        cnt = 0;
        while (r > 2) begin
            r   = csa_next_rows(r);
            cnt = cnt + 1;
        end
        return cnt;
    endfunction

endpackage

// File: rtl/booth_operand_ext.sv
// Module: booth_operand_ext
// Widens an operand by one bit so that a signed core can handle it:
// the new MSB repeats the sign bit for signed operands, else is zero.
// Assumes OP_W >= 2.
module booth_operand_ext #(
    parameter int OP_W = 32
) (
    input  logic [OP_W-1:0] opnd_i,
    input  logic            is_signed_i,
    output logic [OP_W:0]   opnd_o
);

    // Select the extension bit from the flag and the operand MSB.
    always_comb begin
        opnd_o = {is_signed_i & opnd_i[OP_W-1], opnd_i};
    end

endmodule

// File: rtl/booth_digit_dec.sv
// Module: booth_digit_dec
// Decodes one overlapping 3-bit group {hi, mid, lo} into a radix-4
// digit: value = -2*hi + mid + lo, expressed as sign and magnitude.
// Group 111 decodes as zero with neg cleared, so no correction is added.
module booth_digit_dec
    import booth_mul_pkg::*;
(
    input  logic [2:0]  grp_i,
    output booth_sel_t  sel_o
);

    // Map the group to negative / x1 / x2 selects.
    always_comb begin
        sel_o.neg = grp_i[2] & ~(grp_i[1] & grp_i[0]);
        sel_o.one = grp_i[1] ^ grp_i[0];
        sel_o.two = (grp_i[2] & ~grp_i[1] & ~grp_i[0])
                  | (~grp_i[2] & grp_i[1] & grp_i[0]);
    end

endmodule

// File: rtl/booth_pp_gen.sv
// Module: booth_pp_gen
// Builds the partial-product rows: one row per radix-4 digit of the
// recoded operand, sign-extended to PROD_W and shifted by 2*digit,
// plus a final correction row holding a +1 at the base of each
// inverted (negative) row. Assumes EXT_W is odd (even operand width).
module booth_pp_gen
    import booth_mul_pkg::*;
#(
    parameter int EXT_W  = 33,
    parameter int PROD_W = 64,
    localparam int DIGITS = (EXT_W + 1) / 2,
    localparam int ROWS   = DIGITS + 1
) (
    input  logic [EXT_W-1:0]             mplier_i,
    input  logic [EXT_W-1:0]             mcand_i,
    output logic [ROWS-1:0][PROD_W-1:0]  rows_o
);

    localparam int MUL_W = EXT_W + 1;
    localparam int PAD_W = 2 * DIGITS + 1;
    localparam int FILL  = PAD_W - 1 - EXT_W;

    logic [PAD_W-1:0]  padded;
    logic [DIGITS-1:0] neg_vec;
    logic [PROD_W-1:0] corr_row;

    // Pad the recoded operand: zero below bit 0, sign copy above.
    always_comb begin
        padded = {{FILL{mplier_i[EXT_W-1]}}, mplier_i, 1'b0};
    end

    for (genvar d = 0; d < DIGITS; d++) begin : g_digit
        booth_sel_t       sel;
        logic [MUL_W-1:0] mag;
        logic [MUL_W-1:0] mult;

        booth_digit_dec u_dec (
            .grp_i (padded[2*d+2 : 2*d]),
            .sel_o (sel)
        );

        // Pick 0, +B or +2B, then invert it for a negative digit.
        always_comb begin
            if (sel.two) begin
                mag = {mcand_i, 1'b0};
            end else if (sel.one) begin
                mag = {mcand_i[EXT_W-1], mcand_i};
            end else begin
                mag = '0;
            end
            mult = sel.neg ? ~mag : mag;
        end

        assign neg_vec[d] = sel.neg;
        assign rows_o[d]  = {{(PROD_W-MUL_W){mult[MUL_W-1]}}, mult} << (2 * d);
    end

    // Gather the +1 completions for every inverted row.
    always_comb begin
        corr_row = '0;
        for (int d = 0; d < DIGITS; d++) begin
            corr_row[2*d] = neg_vec[d];
        end
    end

    assign rows_o[DIGITS] = corr_row;

endmodule

// File: rtl/booth_csa3.sv
// Module: booth_csa3
// One 3:2 counter row: three W-bit addends become a sum and a carry
// vector of equal total modulo 2^W. The carry out of the MSB is dropped.
module booth_csa3 #(
    parameter int W = 64
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] c_i,
    output logic [W-1:0] sum_o,
    output logic [W-1:0] cy_o
);

    logic [W-2:0] maj;

    // Bitwise parity and majority, carries moved up one weight.
    always_comb begin
        sum_o = a_i ^ b_i ^ c_i;
        maj   = (a_i[W-2:0] & b_i[W-2:0])
              | (a_i[W-2:0] & c_i[W-2:0])
              | (b_i[W-2:0] & c_i[W-2:0]);
        cy_o  = {maj, 1'b0};
    end

endmodule

// File: rtl/booth_csa_tree.sv
// Module: booth_csa_tree
// Reduces N rows to two by levels of 3:2 counters. At each level every
// full group of three rows is compressed and the leftover rows are
// passed through. The level count comes from the package. Assumes N >= 3.
module booth_csa_tree
    import booth_mul_pkg::*;
#(
    parameter int W = 64,
    parameter int N = 18
) (
    input  logic [N-1:0][W-1:0] rows_i,
    output logic [W-1:0]        sum_o,
    output logic [W-1:0]        carry_o
);

    localparam int LEVELS = csa_levels(N);

    for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
        localparam int N_IN = csa_rows_at(N, l);
        logic [W-1:0] v [N_IN];

        if (l == 0) begin : g_load
            for (genvar k = 0; k < N; k++) begin : g_row
                assign v[k] = rows_i[k];
            end
        end else begin : g_red
            localparam int N_PREV = csa_rows_at(N, l - 1);
            localparam int GROUPS = N_PREV / 3;
            localparam int REM    = N_PREV % 3;

            for (genvar g = 0; g < GROUPS; g++) begin : g_grp
                booth_csa3 #(.W(W)) u_csa (
                    .a_i   (g_lvl[l-1].v[3*g]),
                    .b_i   (g_lvl[l-1].v[3*g+1]),
                    .c_i   (g_lvl[l-1].v[3*g+2]),
                    .sum_o (v[2*g]),
                    .cy_o  (v[2*g+1])
                );
            end
            for (genvar r = 0; r < REM; r++) begin : g_pass
                assign v[2*GROUPS+r] = g_lvl[l-1].v[3*GROUPS+r];
            end
        end
    end

    assign sum_o   = g_lvl[LEVELS].v[0];
    assign carry_o = g_lvl[LEVELS].v[1];

endmodule

// File: rtl/booth_mul_top.sv
// Module: booth_mul_top
// Combinational OP_W x OP_W multiplier with a signedness flag per
// operand. Both operands are widened by one bit, op_a is radix-4 Booth
// recoded, the rows are compressed and a final adder forms the product.
// Assumes OP_W is even. There is no clock or reset because the block holds no state.
module booth_mul_top #(
    parameter int OP_W = 32
) (
    input  logic [OP_W-1:0]   op_a,
    input  logic              op_a_signed,
    input  logic [OP_W-1:0]   op_b,
    input  logic              op_b_signed,
    output logic [2*OP_W-1:0] product
);

    localparam int EXT_W  = OP_W + 1;
    localparam int PROD_W = 2 * OP_W;
    localparam int DIGITS = (EXT_W + 1) / 2;
    localparam int ROWS   = DIGITS + 1;

    logic [EXT_W-1:0]            a_ext;
    logic [EXT_W-1:0]            b_ext;
    logic [ROWS-1:0][PROD_W-1:0] pp_rows;
    logic [PROD_W-1:0]           red_sum;
    logic [PROD_W-1:0]           red_carry;

    booth_operand_ext #(.OP_W(OP_W)) u_ext_a (
        .opnd_i      (op_a),
        .is_signed_i (op_a_signed),
        .opnd_o      (a_ext)
    );

    booth_operand_ext #(.OP_W(OP_W)) u_ext_b (
        .opnd_i      (op_b),
        .is_signed_i (op_b_signed),
        .opnd_o      (b_ext)
    );

    booth_pp_gen #(.EXT_W(EXT_W), .PROD_W(PROD_W)) u_pp (
        .mplier_i (a_ext),
        .mcand_i  (b_ext),
        .rows_o   (pp_rows)
    );

    booth_csa_tree #(.W(PROD_W), .N(ROWS)) u_tree (
        .rows_i  (pp_rows),
        .sum_o   (red_sum),
        .carry_o (red_carry)
    );

    // Final carry-propagate addition of the two reduced vectors.
    always_comb begin
        product = red_sum + red_carry;
    end

endmodule

// File: rtl/booth_mul_chk.sv
// Module: booth_mul_chk
// Property checker for booth_mul_top, attached by bind. The checks are
// immediate ones because the block has no clock. The reference value is
// built from the flag-selected 2*OP_W-bit extensions of the pins.
module booth_mul_chk #(
    parameter int OP_W = 32
) (
    input logic [OP_W-1:0]   op_a,
    input logic              op_a_signed,
    input logic [OP_W-1:0]   op_b,
    input logic              op_b_signed,
    input logic [2*OP_W-1:0] product
);

    localparam int PW = 2 * OP_W;

    logic [PW-1:0] wa;
    logic [PW-1:0] wb;
    logic [PW-1:0] exp_p;

    // Extend both pins per their flags and form the modular product.
    always_comb begin
        wa    = {{OP_W{op_a_signed & op_a[OP_W-1]}}, op_a};
        wb    = {{OP_W{op_b_signed & op_b[OP_W-1]}}, op_b};
        exp_p = wa * wb;
    end

    // Mode-wise exactness, zero and unit operands, signed sign rule.
    always_comb begin
        if (!op_a_signed && !op_b_signed) begin
            a_r1_unsigned_exact: assert (product == exp_p);
        end
        if (op_a_signed && op_b_signed) begin
            a_r2_signed_exact: assert (product == exp_p);
        end
        if (op_a_signed && !op_b_signed) begin
            a_r3_mixed_a_exact: assert (product == exp_p);
        end
        if (!op_a_signed && op_b_signed) begin
            a_r4_mixed_b_exact: assert (product == exp_p);
        end
        if (op_a == '0 || op_b == '0) begin
            a_r5_zero_operand: assert (product == '0);
        end
        if (op_a == OP_W'(1)) begin
            a_r6_unit_operand: assert (product == wb);
        end
        if (op_a_signed && op_b_signed && op_a != '0 && op_b != '0) begin
            a_r8_sign_rule: assert (product[PW-1] == (op_a[OP_W-1] ^ op_b[OP_W-1]));
        end
    end

endmodule

bind booth_mul_top booth_mul_chk #(.OP_W(OP_W)) u_chk (.*);

// File: tb/booth_mul_top_tb.sv
// Bench for booth_mul_top. Operands change on the falling edge and the
// product is sampled 5 ns later, inside the same clock period.
module booth_mul_top_tb;

    logic        clk;
    logic        rst_n;
    logic [31:0] op_a;
    logic        op_a_signed;
    logic [31:0] op_b;
    logic        op_b_signed;
    logic [63:0] product;

    int checks;
    int errors;
    bit done;

    booth_mul_top #(.OP_W(32)) u_dut (
        .op_a        (op_a),
        .op_a_signed (op_a_signed),
        .op_b        (op_b),
        .op_b_signed (op_b_signed),
        .product     (product)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    // Reference: flag-selected 64-bit extension, modular product.
    function automatic logic [63:0] ref_mul(logic [31:0] a, logic sa,
                                            logic [31:0] b, logic sb);
        logic [63:0] wa;
        logic [63:0] wb;
        wa = sa ? {{32{a[31]}}, a} : {32'd0, a};
        wb = sb ? {{32{b[31]}}, b} : {32'd0, b};
        return wa * wb;
    endfunction

    function automatic string mode_tag(logic sa, logic sb);
        if (!sa && !sb) return "R1";
        if (sa && sb)   return "R2";
        if (sa)         return "R3";
        return "R4";
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h (a=%h sa=%0b b=%h sb=%0b)",
                     tag, act, exp, op_a, op_a_signed, op_b, op_b_signed);
        end
    endtask

    // Drive on the falling edge; the result is due in the same period.
    task automatic apply(logic [31:0] a, logic sa, logic [31:0] b, logic sb);
        @(negedge clk);
        op_a        = a;
        op_a_signed = sa;
        op_b        = b;
        op_b_signed = sb;
        #5;
    endtask

    task automatic run_pair(logic [31:0] a, logic sa, logic [31:0] b, logic sb);
        apply(a, sa, b, sb);
        check(mode_tag(sa, sb), product, ref_mul(a, sa, b, sb));
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] corners [6];
        logic [63:0] p0;
        logic [63:0] p1;
        logic [31:0] ra;
        logic [31:0] rb;
        corners[0] = 32'h0000_0000;
        corners[1] = 32'h0000_0001;
        corners[2] = 32'h8000_0000;
        corners[3] = 32'hFFFF_FFFF;
        corners[4] = 32'h7FFF_FFFF;
        corners[5] = 32'h0000_0002;
        checks = 0;
        errors = 0;
        done   = 1'b0;
        rst_n  = 1'b0;
        op_a = '0; op_b = '0; op_a_signed = 1'b0; op_b_signed = 1'b0;

        // Idle state: zero operands give a zero product (R5), no edge needed (R9).
        #5;
        check("R5 idle", product, 64'd0);
        repeat (2) @(posedge clk);
        rst_n = 1'b1;

        // R9: product follows the inputs with no clock edge in between.
        @(negedge clk);
        op_a = 32'd3; op_b = 32'd5; op_a_signed = 1'b0; op_b_signed = 1'b0;
        #2;
        check("R9 comb", product, 64'd15);
        op_a = 32'hFFFF_FFFE; op_a_signed = 1'b1;
        #2;
        check("R9 comb", product, 64'hFFFF_FFFF_FFFF_FFF6);

        // R1..R4 corner grid in every flag mode.
        for (int m = 0; m < 4; m++) begin
            for (int i = 0; i < 6; i++) begin
                for (int j = 0; j < 6; j++) begin
                    run_pair(corners[i], m[1], corners[j], m[0]);
                end
            end
        end

        // Hand-computed anchors.
        apply(32'hFFFF_FFFF, 1'b0, 32'hFFFF_FFFF, 1'b0);
        check("R1 max*max", product, 64'hFFFF_FFFE_0000_0001);
        apply(32'h8000_0000, 1'b1, 32'h8000_0000, 1'b1);
        check("R2 min*min", product, 64'h4000_0000_0000_0000);
        apply(32'hFFFF_FFFF, 1'b1, 32'hFFFF_FFFF, 1'b0);
        check("R3 -1*max", product, 64'hFFFF_FFFF_0000_0001);
        apply(32'h0000_0002, 1'b0, 32'h8000_0000, 1'b1);
        check("R4 2*min", product, 64'hFFFF_FFFF_0000_0000);

        // R5: zero on either side in every mode.
        for (int m = 0; m < 4; m++) begin
            apply(32'd0, m[1], 32'hDEAD_BEEF, m[0]);
            check("R5 zero a", product, 64'd0);
            apply(32'hCAFE_F00D, m[1], 32'd0, m[0]);
            check("R5 zero b", product, 64'd0);
        end

        // R6: unit op_a returns op_b extended per its flag.
        apply(32'd1, 1'b0, 32'h9000_0001, 1'b1);
        check("R6 unit sext", product, 64'hFFFF_FFFF_9000_0001);
        apply(32'd1, 1'b1, 32'h9000_0001, 1'b0);
        check("R6 unit zext", product, 64'h0000_0000_9000_0001);

        // R7: the flag of an operand with MSB 0 does nothing.
        for (int k = 0; k < 200; k++) begin
            ra = $urandom & 32'h7FFF_FFFF;
            rb = $urandom;
            apply(ra, 1'b0, rb, k[0]);
            p0 = product;
            apply(ra, 1'b1, rb, k[0]);
            p1 = product;
            check("R7 a flag", p1, p0);
            apply(rb, k[0], ra, 1'b0);
            p0 = product;
            apply(rb, k[0], ra, 1'b1);
            p1 = product;
            check("R7 b flag", p1, p0);
        end

        // R8: signed sign rule on nonzero random operands.
        for (int k = 0; k < 300; k++) begin
            ra = $urandom | 32'd1;
            rb = $urandom | 32'h100;
            apply(ra, 1'b1, rb, 1'b1);
            check("R8 sign", {63'd0, product[63]}, {63'd0, ra[31] ^ rb[31]});
        end

        // Random pairs in all four modes, some with forced edge bits.
        for (int k = 0; k < 8000; k++) begin
            ra = $urandom;
            rb = $urandom;
            if (k % 7 == 0) ra = ra | 32'h8000_0000;
            if (k % 11 == 0) rb = rb & 32'h0000_FFFF;
            if (k % 13 == 0) ra = {ra[31], 31'h7FFF_FFFF};
            run_pair(ra, k[0], rb, k[1]);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule